// File: doc/BRIEF.md
# Codec Register Access Unit

This unit carries one host access to a codec control register across the serial audio link. The host writes a single 32-bit command word. The unit holds it and presents a formatted command-address slot and command-data slot, with their tag bits, to the frame shifter until the next outgoing frame is loaded. It then tracks the transaction until it completes.

A write completes when the frame that carries it has been shifted out. A read completes when the first incoming frame after that point has its status-data slot flagged valid. The 16-bit value is taken from that slot and kept for the host. Each kind of completion sets its own sticky status bit, which can raise an interrupt through a mask. The bit shifter and the frame sync generator sit outside the unit. They talk to it through per-frame strobes and parallel slot words.

Top module: `codec_reg_access`

## Requirements
- R1: After reset the unit is idle: busy_o=0, both tag outputs 0, status_o=0, irq_o=0 and rd_data_o=0.
- R2: The command word is decoded as follows: bit 31 is the direction (1 = read, 0 = write), bits 22:16 are the 7-bit register address and bits 15:0 are the write data. Bits 30:23 are ignored. A word written with cmd_we_i while idle is accepted, and busy_o is 1 from the next cycle.
- R3: While a command is held, cmd_slot_o bit 19 carries the direction, bits 18:12 carry the address and bits 11:0 are zero. data_slot_o bits 19:4 carry the write data and bits 3:0 are zero.
- R4: cmd_tag_o and data_tag_o are 1 from the cycle after acceptance through the cycle in which frame_start_i is sampled. They are 0 afterwards, so only one frame carries the command.
- R5: For a write, the tx_frame_done_i pulse after the carrying frame was loaded ends the transaction. In the next cycle status_o bit 0 is 1 and busy_o is 0.
- R6: For a read, only an rx_frame_i with rx_slot2_tag_i=1 that arrives after the carrying frame was shifted out completes the transaction. Incoming frames before that point, or with the tag clear, leave busy_o=1 and status_o unchanged.
- R7: On read completion, rd_data_o becomes {16'h0000, rx_slot2_i[19:4]} in the next cycle, and status_o bit 1 is set. A write leaves rd_data_o unchanged.
- R8: A cmd_we_i while busy is ignored. The held slots and the transaction that follows belong to the first command.
- R9: status_o bit 0 (write done) and bit 1 (read done) stay set until int_clr_i is pulsed with a 1 in that bit. A set and a clear of the same bit in the same cycle leave the bit set.
- R10: irq_o is 1 exactly when some bit of status_o is set and the matching bit of int_mask_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Host write strobe for the command word |
| cmd_i | input | 32 | Command word |
| int_mask_i | input | 2 | Interrupt enable per status bit |
| int_clr_i | input | 2 | Write-one-to-clear pulse per status bit |
| frame_start_i | input | 1 | Shifter loads the outgoing frame this cycle |
| tx_frame_done_i | input | 1 | Outgoing frame fully shifted out |
| rx_frame_i | input | 1 | Incoming frame slots valid this cycle |
| rx_slot2_tag_i | input | 1 | Incoming status-data slot tagged valid |
| rx_slot2_i | input | 20 | Incoming status-data slot |
| cmd_slot_o | output | 20 | Outgoing command-address slot |
| data_slot_o | output | 20 | Outgoing command-data slot |
| cmd_tag_o | output | 1 | Tag bit for the command-address slot |
| data_tag_o | output | 1 | Tag bit for the command-data slot |
| busy_o | output | 1 | A transaction is pending |
| rd_data_o | output | 32 | Read result, upper half zero |
| status_o | output | 2 | Sticky done flags: bit 0 write, bit 1 read |
| irq_o | output | 1 | Masked interrupt |

## Verification
The bench sweeps every register address in both directions. The write data and returned values are derived arithmetically from the address. This sweep would expose a swapped or shifted slot field, or a result taken from the wrong bits of slot 2.

For reads, the bench injects a tagged incoming frame before the request has gone out, and an untagged frame after it. A unit that completed early would report a stale value, and one that ignored the tag would report garbage.

The bench also fires a second command while the first is pending, which would overwrite the held slots in a unit without the busy guard. Finally, it applies set and clear to the same status bit in one cycle: a wrong priority there would lose a completion event.

// File: rtl/cra_pkg.sv
package cra_pkg;
  localparam int CMD_W    = 32;
  localparam int DIR_BIT  = 31;
  localparam int ADDR_W   = 7;
  localparam int ADDR_LSB = 16;
  localparam int DATA_W   = 16;
  localparam int SLOT_W   = 20;
  localparam int N_SRC    = 2;
  localparam int SRC_WR   = 0;
  localparam int SRC_RD   = 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_SENT,
    ST_WAIT_RX
  } cra_state_e;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cra_cmd_t;
endpackage

// File: rtl/cra_seq.sv
module cra_seq
  import cra_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cmd_we_i,
  input  cra_cmd_t cmd_i,
  input  logic     frame_start_i,
  input  logic     tx_frame_done_i,
  input  logic     rx_frame_i,
  input  logic     rx_tag_i,
  output cra_cmd_t cmd_o,
  output logic     armed_o,
  output logic     busy_o,
  output logic     wr_done_o,
  output logic     rd_done_o
);
  cra_state_e state_q, state_d;
  cra_cmd_t   cmd_q;
  logic       accept;

  assign accept = cmd_we_i && (state_q == ST_IDLE);

  always_comb begin
    state_d   = state_q;
    wr_done_o = 1'b0;
    rd_done_o = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (cmd_we_i) state_d = ST_ARMED;
      ST_ARMED: if (frame_start_i) state_d = ST_SENT;
      ST_SENT: if (tx_frame_done_i) begin
        if (cmd_q.rd) state_d = ST_WAIT_RX;
        else begin
          state_d   = ST_IDLE;
          wr_done_o = 1'b1;
        end
      end
      ST_WAIT_RX: if (rx_frame_i && rx_tag_i) begin
        state_d   = ST_IDLE;
        rd_done_o = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) cmd_q <= cmd_i;
    end
  end

  assign cmd_o   = cmd_q;
  assign armed_o = (state_q == ST_ARMED);
  assign busy_o  = (state_q != ST_IDLE);

  // held command must not move while a transaction is pending
  assert_hold_while_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cmd_we_i |=> $stable(cmd_o));
  // the command rides in exactly one frame
  assert_single_frame_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o && frame_start_i |=> !armed_o && busy_o);
  assert_done_ends_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_done_o || rd_done_o) |=> !busy_o);
endmodule

// File: rtl/cra_slot_fmt.sv
module cra_slot_fmt
  import cra_pkg::*;
#(
  parameter int SW = SLOT_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  cra_cmd_t       cmd_i,
  input  logic           armed_i,
  output logic [SW-1:0]  cmd_slot_o,
  output logic [SW-1:0]  data_slot_o,
  output logic           cmd_tag_o,
  output logic           data_tag_o
);
  localparam int CMD_PAD  = SW - 1 - AW;
  localparam int DATA_PAD = SW - DW;

  assign cmd_slot_o  = {cmd_i.rd, cmd_i.addr, {CMD_PAD{1'b0}}};
  assign data_slot_o = {cmd_i.data, {DATA_PAD{1'b0}}};
  assign cmd_tag_o   = armed_i;
  assign data_tag_o  = armed_i;
endmodule

// File: rtl/cra_resp.sv
module cra_resp
  import cra_pkg::*;
#(
  parameter int NS = N_SRC,
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_done_i,
  input  logic          rd_done_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic [NS-1:0] int_clr_i,
  input  logic [NS-1:0] int_mask_i,
  output logic [NS-1:0] status_o,
  output logic [DW-1:0] result_o,
  output logic          irq_o
);
  logic [NS-1:0] set_vec;

  always_comb begin
    set_vec         = '0;
    set_vec[SRC_WR] = wr_done_i;
    set_vec[SRC_RD] = rd_done_i;
  end

  for (genvar i = 0; i < NS; i++) begin : g_src
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            flag_q <= 1'b0;
      else if (set_vec[i])    flag_q <= 1'b1;   // set beats clear
      else if (int_clr_i[i])  flag_q <= 1'b0;
    end
    assign status_o[i] = flag_q;

    assert_flag_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_o[i]) |-> $past(set_vec[i]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        result_o <= '0;
    else if (rd_done_i) result_o <= rx_data_i;
  end

  assign irq_o = |(status_o & int_mask_i);

  assert_result_only_on_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> $past(rd_done_i));
  assert_read_sets_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_i |=> status_o[SRC_RD]);
endmodule

// File: rtl/codec_reg_access.sv
module codec_reg_access
  import cra_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_we_i,
  input  logic [CMD_W-1:0]    cmd_i,
  input  logic [N_SRC-1:0]    int_mask_i,
  input  logic [N_SRC-1:0]    int_clr_i,
  input  logic                frame_start_i,
  input  logic                tx_frame_done_i,
  input  logic                rx_frame_i,
  input  logic                rx_slot2_tag_i,
  input  logic [SLOT_W-1:0]   rx_slot2_i,
  output logic [SLOT_W-1:0]   cmd_slot_o,
  output logic [SLOT_W-1:0]   data_slot_o,
  output logic                cmd_tag_o,
  output logic                data_tag_o,
  output logic                busy_o,
  output logic [CMD_W-1:0]    rd_data_o,
  output logic [N_SRC-1:0]    status_o,
  output logic                irq_o
);
  localparam int RX_LSB = SLOT_W - DATA_W;

  cra_cmd_t          cmd_in, cmd_held;
  logic              armed, wr_done, rd_done;
  logic [DATA_W-1:0] result;
  logic              unused_bits;

  assign cmd_in.rd   = cmd_i[DIR_BIT];
  assign cmd_in.addr = cmd_i[ADDR_LSB +: ADDR_W];
  assign cmd_in.data = cmd_i[DATA_W-1:0];
  assign unused_bits = ^{cmd_i[DIR_BIT-1:ADDR_LSB+ADDR_W], rx_slot2_i[RX_LSB-1:0]};

  cra_seq u_seq (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .cmd_we_i        (cmd_we_i),
    .cmd_i           (cmd_in),
    .frame_start_i   (frame_start_i),
    .tx_frame_done_i (tx_frame_done_i),
    .rx_frame_i      (rx_frame_i),
    .rx_tag_i        (rx_slot2_tag_i),
    .cmd_o           (cmd_held),
    .armed_o         (armed),
    .busy_o          (busy_o),
    .wr_done_o       (wr_done),
    .rd_done_o       (rd_done)
  );

  cra_slot_fmt u_fmt (
    .cmd_i       (cmd_held),
    .armed_i     (armed),
    .cmd_slot_o  (cmd_slot_o),
    .data_slot_o (data_slot_o),
    .cmd_tag_o   (cmd_tag_o),
    .data_tag_o  (data_tag_o)
  );

  cra_resp u_resp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_done_i  (wr_done),
    .rd_done_i  (rd_done),
    .rx_data_i  (rx_slot2_i[SLOT_W-1:RX_LSB]),
    .int_clr_i  (int_clr_i),
    .int_mask_i (int_mask_i),
    .status_o   (status_o),
    .result_o   (result),
    .irq_o      (irq_o)
  );

  assign rd_data_o = {{(CMD_W-DATA_W){1'b0}}, result};

  // a read must not finish before its frame was even loaded
  assert_no_early_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_tag_o |=> !status_o[SRC_RD] || $past(status_o[SRC_RD]));
  assert_tags_paired_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_tag_o |-> busy_o);
endmodule

// File: tb/codec_reg_access_tb_top.sv
module codec_reg_access_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 100000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd = '0;
  logic [1:0]  int_mask = '0, int_clr = '0;
  logic        frame_start = 1'b0, tx_done = 1'b0, rx_frame = 1'b0, rx_tag = 1'b0;
  logic [19:0] rx_slot = '0;
  logic [19:0] cmd_slot, data_slot;
  logic        cmd_tag, data_tag, busy, irq;
  logic [31:0] rd_data;
  logic [1:0]  status;

  int n_chk = 0, n_bad = 0;
  logic [15:0] last_rv = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_reg_access dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_we_i(cmd_we), .cmd_i(cmd),
    .int_mask_i(int_mask), .int_clr_i(int_clr), .frame_start_i(frame_start),
    .tx_frame_done_i(tx_done), .rx_frame_i(rx_frame), .rx_slot2_tag_i(rx_tag),
    .rx_slot2_i(rx_slot), .cmd_slot_o(cmd_slot), .data_slot_o(data_slot),
    .cmd_tag_o(cmd_tag), .data_tag_o(data_tag), .busy_o(busy),
    .rd_data_o(rd_data), .status_o(status), .irq_o(irq)
  );

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic send(input logic rd, input logic [6:0] a, input logic [15:0] d);
    cmd = {rd, 8'h00, a, d};
    cmd_we = 1'b1;
    tick;
    cmd_we = 1'b0;
    chk("R2 busy", {31'b0, busy}, 32'd1);
    chk("R3 cmd slot", {12'b0, cmd_slot}, {12'b0, rd, a, 12'h000});
    chk("R3 data slot", {12'b0, data_slot}, {12'b0, d, 4'h0});
    chk("R4 tags held", {30'b0, cmd_tag, data_tag}, 32'd3);
  endtask

  task automatic launch;
    frame_start = 1'b1;
    tick;
    frame_start = 1'b0;
    chk("R4 tags dropped", {30'b0, cmd_tag, data_tag}, 32'd0);
    chk("R4 busy", {31'b0, busy}, 32'd1);
    tick;
  endtask

  task automatic txn(input logic rd, input logic [6:0] a, input logic [15:0] d,
                     input logic [15:0] rv);
    int_mask = a[1:0];
    send(rd, a, d);
    if (a[2:0] == 3'd3) begin
      cmd = ~cmd;
      cmd_we = 1'b1;
      tick;
      cmd_we = 1'b0;
      chk("R8 cmd slot kept", {12'b0, cmd_slot}, {12'b0, rd, a, 12'h000});
      chk("R8 data slot kept", {12'b0, data_slot}, {12'b0, d, 4'h0});
    end
    if (rd) begin
      rx_frame = 1'b1; rx_tag = 1'b1; rx_slot = 20'hFFFFF;
      tick;
      rx_frame = 1'b0; rx_tag = 1'b0;
      chk("R6 early rx ignored", {30'b0, status}, 32'd0);
      chk("R6 early rx busy", {31'b0, busy}, 32'd1);
    end
    launch;
    tx_done = 1'b1;
    tick;
    tx_done = 1'b0;
    if (!rd) begin
      chk("R5 write done flag", {30'b0, status}, 32'd1);
      chk("R5 idle", {31'b0, busy}, 32'd0);
      chk("R10 irq write", {31'b0, irq}, {31'b0, a[0]});
      chk("R7 write keeps result", rd_data, {16'h0, last_rv});
    end else begin
      chk("R6 waiting", {30'b0, status, busy}, 32'd1);
      rx_frame = 1'b1; rx_tag = 1'b0; rx_slot = {~rv, 4'h5};
      tick;
      chk("R6 untagged ignored", {30'b0, status, busy}, 32'd1);
      rx_tag = 1'b1; rx_slot = {rv, a[3:0]};
      tick;
      rx_frame = 1'b0; rx_tag = 1'b0;
      last_rv = rv;
      chk("R7 read data", rd_data, {16'h0, rv});
      chk("R7 read done flag", {30'b0, status}, 32'd2);
      chk("R6 idle after read", {31'b0, busy}, 32'd0);
      chk("R10 irq read", {31'b0, irq}, {31'b0, a[1]});
    end
    int_clr = 2'b11;
    tick;
    int_clr = 2'b00;
    chk("R9 cleared", {30'b0, status}, 32'd0);
    chk("R10 irq low", {31'b0, irq}, 32'd0);
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary;
  end

  initial begin
    tick; tick;
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 tags", {30'b0, cmd_tag, data_tag}, 32'd0);
    chk("R1 status irq", {29'b0, status, irq}, 32'd0);
    chk("R1 rd data", rd_data, 32'd0);
    rst_ni = 1'b1;
    tick;

    for (int a = 0; a < 128; a++) begin
      for (int r = 0; r < 2; r++) begin
        logic [15:0] d, rv;
        d  = 16'(a * 16'h0123) ^ 16'hA5A5;
        rv = 16'(a * 16'h03F1) ^ 16'h5A3C;
        txn(r[0], a[6:0], d, rv);
      end
    end

    // R9 set/clear collision and per-bit clear
    int_mask = 2'b11;
    send(1'b0, 7'h2A, 16'hBEEF);
    launch;
    tx_done = 1'b1; int_clr = 2'b01;
    tick;
    tx_done = 1'b0; int_clr = 2'b00;
    chk("R9 set wins", {30'b0, status}, 32'd1);
    send(1'b1, 7'h15, 16'h0000);
    launch;
    tx_done = 1'b1;
    tick;
    tx_done = 1'b0;
    rx_frame = 1'b1; rx_tag = 1'b1; rx_slot = {16'hC0DE, 4'hF};
    tick;
    rx_frame = 1'b0; rx_tag = 1'b0;
    chk("R9 both sticky", {30'b0, status}, 32'd3);
    chk("R7 read data directed", rd_data, 32'h0000C0DE);
    int_clr = 2'b01;
    tick;
    int_clr = 2'b00;
    chk("R9 per-bit clear", {30'b0, status}, 32'd2);
    int_mask = 2'b01;
    tick;
    chk("R10 masked source", {31'b0, irq}, 32'd0);
    int_clr = 2'b10;
    tick;
    int_clr = 2'b00;
    chk("R9 final clear", {30'b0, status}, 32'd0);
    summary;
  end
endmodule